// File: doc/BRIEF.md
# Flash Block Erase-Verify Sequencer

This block runs the complete erase of a single flash block. It drives the strobes of a flash array port: write enable, erase setup, erase pulse, erase verify, a one-hot block select and a watchdog enable. It then checks that every word of the block reads back as erased. A caller pulses `start` together with a one-hot block mask while the sequencer is idle. The sequencer then walks a fixed, interlocked series of timed phases and finishes with a one-cycle `done` or `fail` pulse.

A single down-counter times every delay. All delays are parameters counted in clock cycles. During verify an address counter walks the block from its first word upward. For each word the sequencer issues a dummy write of 0xFF and waits, then reads one 16-bit word, which passes only if every bit is 1. If any word fails, the sequencer stops verifying and fires the whole erase pulse again, up to a bounded number of attempts. The block is never preprogrammed to zeros. Only one block is handled per request.

Top module: `flash_erase_seq`

## Requirements
- R1: A `start` is taken only while idle and only with exactly one bit of `blk_sel` set. A start in idle with zero or several bits set produces a one-cycle `rej` one cycle later and raises no strobe. A start while busy has no effect on the run in progress.
- R2: After acceptance `fl_swe` rises first. D_X cycles later `fl_blk`, `wdt_en` and `fl_esu` rise together.
- R3: `fl_erase` rises D_Y cycles after `fl_esu` rises and stays high D_Z cycles. `fl_esu` falls D_A cycles after `fl_erase` falls.
- R4: `fl_erase` is high only while `fl_esu`, `fl_swe` and `wdt_en` are all high.
- R5: D_B cycles after `fl_esu` falls, `wdt_en` drops and `fl_ev` rises in the same cycle. The first dummy write comes D_G cycles after `fl_ev` rises.
- R6: Each verify step pulses `fl_wr` for one cycle with `fl_wdata` = 16'h00FF. D_E+1 cycles later it pulses `fl_rd` at the same address. Addresses are {block index, word offset} with the offset in the low log2(WORDS) bits, rising from 0.
- R7: A word passes only if it reads 16'hFFFF. A pass at the last offset drops `fl_ev` and `fl_swe` together, and `done` pulses D_H cycles later.
- R8: A failing word ends the verify pass and drops `fl_ev`. D_H cycles later either `fl_esu` rises again for a new attempt, or, once MAX_TRY attempts have been made, `fl_swe` drops and `fail` pulses.
- R9: `busy` is high from the cycle after acceptance until the cycle in which `done` or `fail` is high. `done` and `fail` last one cycle each and never coincide.
- R10: Under reset every strobe, `busy`, `done`, `fail` and `rej` are low.
- R11: `fl_blk` is either zero or equal to the accepted mask, and it stays constant while nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request pulse |
| blk_sel | input | NBLK | One-hot block mask |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Erase verified, one cycle |
| fail | output | 1 | Attempt limit reached, one cycle |
| rej | output | 1 | Malformed request refused, one cycle |
| fl_swe | output | 1 | Flash write enable |
| fl_esu | output | 1 | Erase setup |
| fl_erase | output | 1 | Erase pulse |
| fl_ev | output | 1 | Erase verify mode |
| fl_blk | output | NBLK | Block select to the array |
| wdt_en | output | 1 | Watchdog enable |
| fl_addr | output | BW+OW | Verify word address |
| fl_wr | output | 1 | Dummy write strobe |
| fl_wdata | output | DW | Dummy write data (0xFF) |
| fl_rd | output | 1 | Verify read strobe |
| fl_rdata | input | DW | Word read from the array |

## Verification
Assertions check the properties that hold every cycle: erase nests inside setup, write enable and watchdog; verify never overlaps setup or watchdog; the block select is one-hot and does not change; `done` and `fail` never coincide; refused and accepted requests react in the next cycle. The exact phase lengths, the address walk, the dummy-write-before-read pairing, the retry count and the reads each pass makes are shown only by the bench scenarios. These drive blocks that need one to several pulses, stuck words at chosen offsets, the first and last block, and starts issued mid-run.

// File: rtl/flash_erase_seq.sv
module flash_erase_seq #(
  parameter int NBLK    = 8,
  parameter int WORDS   = 4,
  parameter int DW      = 16,
  parameter int CW      = 16,
  parameter int D_X     = 3,
  parameter int D_Y     = 2,
  parameter int D_Z     = 6,
  parameter int D_A     = 2,
  parameter int D_B     = 2,
  parameter int D_G     = 3,
  parameter int D_E     = 2,
  parameter int D_H     = 3,
  parameter int MAX_TRY = 3,
  localparam int BW = $clog2(NBLK),
  localparam int OW = $clog2(WORDS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [NBLK-1:0] blk_sel,
  output logic            busy,
  output logic            done,
  output logic            fail,
  output logic            rej,
  output logic            fl_swe,
  output logic            fl_esu,
  output logic            fl_erase,
  output logic            fl_ev,
  output logic [NBLK-1:0] fl_blk,
  output logic            wdt_en,
  output logic [BW+OW-1:0] fl_addr,
  output logic            fl_wr,
  output logic [DW-1:0]   fl_wdata,
  output logic            fl_rd,
  input  logic [DW-1:0]   fl_rdata
);
  localparam int NW = $clog2(MAX_TRY + 1);

  typedef enum logic [3:0] {
    IDLE, S_X, S_Y, S_Z, S_A, S_B, S_G, S_WR, S_E, S_RD, S_H, S_Q
  } st_t;

  st_t             st;
  logic [CW-1:0]   cnt;
  logic [NW-1:0]   n;
  logic [OW-1:0]   offs;
  logic [BW-1:0]   bidx;
  logic [NBLK-1:0] mask;

  wire tick   = (cnt == '0);
  wire req_ok = ($countones(blk_sel) == 1);

  function automatic logic [BW-1:0] enc(input logic [NBLK-1:0] m);
    enc = '0;
    for (int i = 0; i < NBLK; i++) if (m[i]) enc = BW'(i);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= IDLE; cnt <= '0; n <= '0; offs <= '0;
      bidx <= '0; mask <= '0; done <= 1'b0; fail <= 1'b0; rej <= 1'b0;
    end else begin
      done <= 1'b0; fail <= 1'b0; rej <= 1'b0;
      if (!tick) cnt <= cnt - 1'b1;
      case (st)
        IDLE: if (start) begin
          if (req_ok) begin
            st <= S_X; cnt <= CW'(D_X - 1); mask <= blk_sel;
            bidx <= enc(blk_sel); n <= NW'(1);
          end else rej <= 1'b1;
        end
        S_X: if (tick) begin st <= S_Y; cnt <= CW'(D_Y - 1); end
        S_Y: if (tick) begin st <= S_Z; cnt <= CW'(D_Z - 1); end
        S_Z: if (tick) begin st <= S_A; cnt <= CW'(D_A - 1); end
        S_A: if (tick) begin st <= S_B; cnt <= CW'(D_B - 1); end
        S_B: if (tick) begin st <= S_G; cnt <= CW'(D_G - 1); end
        S_G: if (tick) begin st <= S_WR; offs <= '0; end
        S_WR: begin st <= S_E; cnt <= CW'(D_E - 1); end
        S_E: if (tick) st <= S_RD;
        S_RD: begin
          if (&fl_rdata) begin
            if (&offs) begin st <= S_Q; cnt <= CW'(D_H - 1); end
            else begin offs <= offs + 1'b1; st <= S_WR; end
          end else begin st <= S_H; cnt <= CW'(D_H - 1); end
        end
        S_H: if (tick) begin
          if (n >= NW'(MAX_TRY)) begin st <= IDLE; fail <= 1'b1; end
          else begin n <= n + 1'b1; st <= S_Y; cnt <= CW'(D_Y - 1); end
        end
        S_Q: if (tick) begin st <= IDLE; done <= 1'b1; end
        default: st <= IDLE;
      endcase
    end
  end

  assign busy     = (st != IDLE);
  assign fl_swe   = (st != IDLE) && (st != S_Q);
  assign fl_esu   = (st == S_Y) || (st == S_Z) || (st == S_A);
  assign wdt_en   = fl_esu || (st == S_B);
  assign fl_erase = (st == S_Z);
  assign fl_ev    = (st == S_G) || (st == S_WR) || (st == S_E) || (st == S_RD);
  assign fl_blk   = (fl_swe && st != S_X) ? mask : '0;
  assign fl_wr    = (st == S_WR);
  assign fl_rd    = (st == S_RD);
  assign fl_addr  = {bidx, offs};
  assign fl_wdata = DW'(8'hFF);

  AST_REJ_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && $countones(blk_sel) != 1) |=> (rej && !busy)); // R1
  AST_ACCEPT_SWE: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && $countones(blk_sel) == 1) |=> (busy && fl_swe && fl_blk == '0)); // R2
  AST_ERASE_NESTED: assert property (@(posedge clk) disable iff (!rst_n)
    fl_erase |-> (fl_esu && fl_swe && wdt_en)); // R4
  AST_EV_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
    fl_ev |-> (!fl_esu && !wdt_en && fl_swe)); // R5
  AST_RD_IN_EV: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_rd || fl_wr) |-> fl_ev); // R6
  AST_END_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && fail)); // R9
  AST_END_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (done || fail) |-> (!busy && !fl_swe && $past(busy))); // R9
  AST_BLK_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(fl_blk)); // R11
  AST_BLK_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_blk != '0 && $past(fl_blk) != '0) |-> $stable(fl_blk)); // R11
endmodule

// File: tb/flash_erase_seq_tb_top.sv
module flash_erase_seq_tb_top;
  localparam int PER = 10;
  localparam int NBLK = 8, WORDS = 4, DW = 16;
  localparam int D_X = 3, D_Y = 2, D_Z = 6, D_A = 2, D_B = 2, D_G = 3, D_E = 2, D_H = 3;
  localparam int MAX_TRY = 3;
  localparam int BW = $clog2(NBLK), OW = $clog2(WORDS), AW = BW + OW;

  logic clk = 0, rst_n = 0, start = 0;
  logic [NBLK-1:0] blk_sel = '0;
  logic busy, done, fail, rej, fl_swe, fl_esu, fl_erase, fl_ev, wdt_en, fl_wr, fl_rd;
  logic [NBLK-1:0] fl_blk;
  logic [AW-1:0] fl_addr;
  logic [DW-1:0] fl_wdata, fl_rdata;

  logic [DW-1:0] mem [NBLK*WORDS];
  assign fl_rdata = mem[fl_addr];

  flash_erase_seq #(.NBLK(NBLK), .WORDS(WORDS), .DW(DW), .CW(16), .D_X(D_X), .D_Y(D_Y),
    .D_Z(D_Z), .D_A(D_A), .D_B(D_B), .D_G(D_G), .D_E(D_E), .D_H(D_H), .MAX_TRY(MAX_TRY)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .blk_sel(blk_sel), .busy(busy), .done(done),
    .fail(fail), .rej(rej), .fl_swe(fl_swe), .fl_esu(fl_esu), .fl_erase(fl_erase), .fl_ev(fl_ev),
    .fl_blk(fl_blk), .wdt_en(wdt_en), .fl_addr(fl_addr), .fl_wr(fl_wr), .fl_wdata(fl_wdata),
    .fl_rd(fl_rd), .fl_rdata(fl_rdata));

  always #(PER/2) clk = ~clk;

  int checks = 0, errs = 0;
  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin errs++; $display("FAIL %s actual=%0d expected=%0d", req, act, exp); end
  endtask

  // run context shared with the monitor
  int need, stuck, pulses, reads, writes, offs_exp, exp_b;
  logic [NBLK-1:0] exp_mask;
  bit first_pulse, first_wr, got_done, got_fail, ev_swe_fell;
  int cyc = 0, t_swe, t_esu, t_er, t_erf, t_esf, t_ev, t_evf, t_wr;
  int wr_addr;
  logic p_swe = 0, p_esu = 0, p_er = 0, p_ev = 0, p_busy = 0;

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (fl_swe && !p_swe) t_swe = cyc;
      if (fl_esu && !p_esu) begin
        if (first_pulse) chk(cyc - t_swe == D_X, "R2 swe->esu", cyc - t_swe, D_X);
        else chk(cyc - t_evf == D_H, "R8 retry gap", cyc - t_evf, D_H);
        chk(wdt_en && fl_blk == exp_mask, "R2 blk/wdt with esu", int'(fl_blk), int'(exp_mask));
        first_pulse = 0; t_esu = cyc;
      end
      if (fl_erase) chk(fl_esu && fl_swe && wdt_en, "R4 erase nesting", 0, 1);
      if (fl_erase && !p_er) begin
        chk(cyc - t_esu == D_Y, "R3 esu->erase", cyc - t_esu, D_Y); t_er = cyc;
      end
      if (!fl_erase && p_er) begin
        chk(cyc - t_er == D_Z, "R3 erase width", cyc - t_er, D_Z); t_erf = cyc;
        chk(fl_blk == exp_mask, "R11 blk during run", int'(fl_blk), int'(exp_mask));
        pulses++;
        if (pulses >= need)
          for (int w = 0; w < WORDS; w++) if (w != stuck) mem[exp_b*WORDS + w] = '1;
      end
      if (!fl_esu && p_esu) begin
        chk(cyc - t_erf == D_A, "R3 erase->esu fall", cyc - t_erf, D_A); t_esf = cyc;
      end
      if (fl_ev && !p_ev) begin
        chk(cyc - t_esf == D_B && !wdt_en, "R5 esu fall->ev", cyc - t_esf, D_B);
        t_ev = cyc; offs_exp = 0; first_wr = 1;
      end
      if (fl_wr) begin
        if (first_wr) chk(cyc - t_ev == D_G, "R5 ev->first write", cyc - t_ev, D_G);
        chk(fl_wdata == 16'h00FF, "R6 dummy data", int'(fl_wdata), 255);
        first_wr = 0; t_wr = cyc; wr_addr = int'(fl_addr); writes++;
      end
      if (fl_rd) begin
        chk(cyc - t_wr == D_E + 1, "R6 write->read", cyc - t_wr, D_E + 1);
        chk(int'(fl_addr) == exp_b*WORDS + offs_exp && wr_addr == int'(fl_addr),
            "R6 address", int'(fl_addr), exp_b*WORDS + offs_exp);
        reads++; offs_exp++;
      end
      if (!fl_ev && p_ev) begin t_evf = cyc; ev_swe_fell = !fl_swe; end
      if (done) begin
        got_done = 1;
        chk(cyc - t_evf == D_H && ev_swe_fell, "R7 done delay", cyc - t_evf, D_H);
        chk(!busy && p_busy && !fail, "R9 done vs busy", int'(busy), 0);
      end
      if (fail) begin
        got_fail = 1;
        chk(cyc - t_evf == D_H && !fl_swe, "R8 fail delay", cyc - t_evf, D_H);
        chk(!busy && p_busy, "R9 fail vs busy", int'(busy), 0);
      end
    end
    p_swe = fl_swe; p_esu = fl_esu; p_er = fl_erase; p_ev = fl_ev; p_busy = busy;
  end

  function automatic int exp_reads(input int nd, input int sk);
    int a_max, r;
    bit ok = (nd <= MAX_TRY) && (sk < 0);
    a_max = ok ? nd : MAX_TRY;
    r = 0;
    for (int a = 1; a <= a_max; a++) r += (a < nd) ? 1 : ((sk < 0) ? WORDS : sk + 1);
    return r;
  endfunction

  task automatic run(input int b, input int nd, input int sk, input bit poke);
    logic [DW-1:0] snap [NBLK*WORDS];
    bit ok = (nd <= MAX_TRY) && (sk < 0);
    int guard = 0;
    for (int i = 0; i < NBLK*WORDS; i++) begin
      mem[i] = DW'($urandom) & ~DW'(1); snap[i] = mem[i];
    end
    exp_b = b; exp_mask = NBLK'(1) << b; need = nd; stuck = sk;
    pulses = 0; reads = 0; writes = 0; first_pulse = 1; got_done = 0; got_fail = 0;
    @(negedge clk); start = 1; blk_sel = exp_mask;
    @(negedge clk); start = 0; blk_sel = '0;
    chk(busy && fl_swe, "R9 busy after accept", int'(busy), 1);
    if (poke) begin
      repeat (12) @(negedge clk);
      start = 1; blk_sel = NBLK'(1) << ((b + 1) % NBLK);
      @(negedge clk); start = 0; blk_sel = '0;
    end
    while (!got_done && !got_fail && guard < 5000) begin @(negedge clk); guard++; end
    chk(got_done == ok && got_fail == !ok, "R7 R8 outcome", int'(got_done), int'(ok));
    chk(pulses == (ok ? nd : MAX_TRY), "R8 pulse count", pulses, ok ? nd : MAX_TRY);
    chk(reads == exp_reads(nd, sk) && writes == reads, "R6 R7 read count", reads, exp_reads(nd, sk));
    for (int i = 0; i < NBLK*WORDS; i++)
      if (i / WORDS != b) chk(mem[i] == snap[i], "R11 other block untouched", int'(mem[i]), int'(snap[i]));
    repeat (2) @(negedge clk);
  endtask

  task automatic try_rej(input logic [NBLK-1:0] m);
    @(negedge clk); start = 1; blk_sel = m;
    @(negedge clk); start = 0; blk_sel = '0;
    chk(rej && !busy && !fl_swe, "R1 reject", int'(rej), 1);
    repeat (3) begin
      @(negedge clk); chk(!busy && !fl_swe && !rej, "R1 stays idle", int'(busy), 0);
    end
  endtask

  initial begin
    #(PER*150000);
    errs++; $display("FAIL watchdog actual=0 expected=1");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(!busy && !done && !fail && !rej && !fl_swe && !fl_esu && !fl_erase && !fl_ev
        && !wdt_en && fl_blk == '0 && !fl_wr && !fl_rd, "R10 reset state", 1, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    try_rej('0);
    try_rej(8'b0001_0100);
    try_rej('1);
    run(0, 1, -1, 0);
    run(NBLK-1, MAX_TRY, -1, 0);
    run(3, MAX_TRY+1, -1, 0);
    run(5, 1, WORDS-1, 0);
    run(2, 2, 0, 0);
    run(4, 1, -1, 1);
    for (int k = 0; k < 12; k++) begin
      int b = int'($urandom_range(NBLK-1, 0));
      int nd = int'($urandom_range(MAX_TRY+1, 1));
      int sk = ($urandom_range(2, 0) == 0) ? int'($urandom_range(WORDS-1, 0)) : -1;
      run(b, nd, sk, k[0]);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
    $finish;
  end
endmodule